// File: doc/BRIEF.md
# SMBus Packet Error Code Append and Check Unit

This unit sits between the byte sequencer of an SMBus host controller and its shift register. It keeps a running 8-bit packet error code (PEC) over every byte that passes on the wire in one transaction. That includes the address byte, the command byte and the address byte sent again after a repeated start. A start-of-packet strobe clears the running code. Each byte-valid strobe folds one whole byte into the code in a single cycle.

With automatic mode on, the unit behaves differently for the two directions. On a write, it offers the computed code as the byte that follows the last data byte. On a read, it compares the final received byte against the code of everything received before it. A mismatch raises two sticky error flags, a device-error flag and a CRC-error flag. Software clears each flag by writing 1 to it.

With automatic mode off and manual PEC enabled, the unit passes on a byte that software wrote into its PEC register instead. Turning on both modes together is an illegal configuration. In that case the unit resolves to automatic behaviour.

Top module: `smbus_pec_unit`

## Requirements
- R1: After reset the running code is 0x00, `pec_vld` and `chk_vld` are low, and both error flags are low.
- R2: The code uses polynomial x^8+x^2+x+1 (0x07), starts at 0x00, and takes bits MSB first. Every strobed byte feeds it, including a repeated-start address byte. The nine ASCII bytes "123456789" give 0xF4, and the single byte 0x01 gives 0x07.
- R3: Each `byte_vld` cycle folds exactly one byte. When `sop` and `byte_vld` are high in the same cycle, the code is cleared first and that byte becomes the first byte of the new packet.
- R4: In automatic mode on a write (`rd_dir`=0), the cycle after a byte strobed with `last_byte` shows `pec_vld` high for exactly one cycle. In that cycle `pec_byte` equals the code over all bytes of the packet.
- R5: In automatic mode, the value in `sw_pec` never appears on `pec_byte` while `pec_vld` is high.
- R6: With `auto_en`=0 and `man_pec_en`=1, a write's last byte is followed one cycle later by `pec_vld` with `pec_byte` equal to `sw_pec`.
- R7: With both `auto_en` and `man_pec_en` low, `pec_vld` never rises.
- R8: In automatic mode on a read (`rd_dir`=1), the byte strobed with `last_byte` is compared against the code of the earlier bytes. One cycle later `chk_vld` pulses, and `chk_ok` is 1 on a match and 0 otherwise.
- R9: A read mismatch sets both `dev_err` and `crc_err` in the cycle that `chk_vld` pulses.
- R10: The error flags are sticky. `err_clr[0]` clears `dev_err` and `err_clr[1]` clears `crc_err`; each clears only its own flag. A new error in the same cycle as a clear wins over the clear.
- R11: A read packet never raises `pec_vld`.
- R12: A matching read leaves both error flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sop | input | 1 | Start of packet; clears the running code |
| byte_vld | input | 1 | A byte is on `byte_in` this cycle |
| byte_in | input | 8 | Byte sent or received on the wire |
| rd_dir | input | 1 | 1 = read packet, 0 = write packet |
| last_byte | input | 1 | Marks the final byte (on a read, the received PEC) |
| auto_en | input | 1 | Automatic PEC append and check |
| man_pec_en | input | 1 | Manual PEC from the software register |
| sw_pec | input | 8 | Software-written PEC value |
| err_clr | input | 2 | Write-1 clear: bit 0 device error, bit 1 CRC error |
| pec_vld | output | 1 | One-cycle pulse: `pec_byte` is to be sent |
| pec_byte | output | 8 | PEC byte for the shifter |
| chk_vld | output | 1 | One-cycle pulse: read check result ready |
| chk_ok | output | 1 | Received PEC matched |
| dev_err | output | 1 | Sticky device error |
| crc_err | output | 1 | Sticky CRC error |

## Verification
The code is checked against the two published vectors: the nine-byte ASCII string and the single byte 0x01. The second vector exposes errors in the polynomial or the bit order that a longer string can hide. A read sequence with a repeated-start address, sent once with the correct final byte and once with a corrupted one, separates correct checking from a check that ignores some bytes or never fails. Further sequences cover manual, automatic and disabled modes, and a strobe that starts a packet in the same cycle as `sop`. These tell apart the source of the appended byte, the clearing order, and how the sticky flags clear one at a time.

// File: rtl/smbus_pec_unit.sv
module smbus_pec_unit #(
  parameter logic [7:0] POLY = 8'h07,
  parameter logic [7:0] INIT = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sop,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  input  logic       rd_dir,
  input  logic       last_byte,
  input  logic       auto_en,
  input  logic       man_pec_en,
  input  logic [7:0] sw_pec,
  input  logic [1:0] err_clr,
  output logic       pec_vld,
  output logic [7:0] pec_byte,
  output logic       chk_vld,
  output logic       chk_ok,
  output logic       dev_err,
  output logic       crc_err
);

  localparam int BW = 8;

  function automatic logic [BW-1:0] step(input logic [BW-1:0] c, input logic [BW-1:0] d);
    logic [BW-1:0] r;
    r = c ^ d;
    for (int i = 0; i < BW; i++)
      r = r[BW-1] ? ((r << 1) ^ POLY) : (r << 1);
    return r;
  endfunction

  logic [7:0] crc_q;
  logic [7:0] base, nxt;
  logic       fin_wr, fin_rd, mism;

  assign base   = sop ? INIT : crc_q;
  assign nxt    = step(base, byte_in);
  assign fin_wr = byte_vld && last_byte && !rd_dir;
  assign fin_rd = byte_vld && last_byte && rd_dir && auto_en;
  assign mism   = fin_rd && (byte_in != base);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q    <= INIT;
      pec_vld  <= 1'b0;
      pec_byte <= 8'h00;
      chk_vld  <= 1'b0;
      chk_ok   <= 1'b0;
      dev_err  <= 1'b0;
      crc_err  <= 1'b0;
    end else begin
      if (byte_vld)  crc_q <= nxt;
      else if (sop)  crc_q <= INIT;
      pec_vld <= fin_wr && (auto_en || man_pec_en);
      if (fin_wr) pec_byte <= auto_en ? nxt : sw_pec;
      chk_vld <= fin_rd;
      if (fin_rd) chk_ok <= !mism;
      if (mism)            dev_err <= 1'b1;
      else if (err_clr[0]) dev_err <= 1'b0;
      if (mism)            crc_err <= 1'b1;
      else if (err_clr[1]) crc_err <= 1'b0;
    end
  end

  AST_PEC_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && last_byte && !rd_dir && auto_en) |=> pec_vld); // R4
  AST_PEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pec_vld && !(byte_vld && last_byte && !rd_dir) |=> !pec_vld); // R4
  AST_NO_PEC_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && rd_dir) |=> !pec_vld); // R11
  AST_NO_PEC_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en && !man_pec_en) |=> !pec_vld); // R7
  AST_ERR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_err) |-> dev_err && chk_vld && !chk_ok); // R9
  AST_CRC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err && !err_clr[1] |=> crc_err); // R10
  AST_DEV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    dev_err && !err_clr[0] |=> dev_err); // R10
  AST_MATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    chk_vld && chk_ok |-> $stable(crc_err)); // R12

endmodule

// File: tb/smbus_pec_unit_tb_top.sv
module smbus_pec_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sop = 0, byte_vld = 0, rd_dir = 0, last_byte = 0, auto_en = 0, man_pec_en = 0;
  logic [7:0] byte_in = 0, sw_pec = 0;
  logic [1:0] err_clr = 0;
  logic pec_vld, chk_vld, chk_ok, dev_err, crc_err;
  logic [7:0] pec_byte;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  smbus_pec_unit dut_i (.clk(clk), .rst_n(rst_n), .sop(sop), .byte_vld(byte_vld),
    .byte_in(byte_in), .rd_dir(rd_dir), .last_byte(last_byte), .auto_en(auto_en),
    .man_pec_en(man_pec_en), .sw_pec(sw_pec), .err_clr(err_clr), .pec_vld(pec_vld),
    .pec_byte(pec_byte), .chk_vld(chk_vld), .chk_ok(chk_ok), .dev_err(dev_err),
    .crc_err(crc_err));

  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int b = 7; b >= 0; b--) begin
      logic fb;
      fb = r[7] ^ d[b];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic s, input logic [7:0] d, input logic lst);
    sop = s; byte_vld = 1; byte_in = d; last_byte = lst;
    @(negedge clk);
    sop = 0; byte_vld = 0; last_byte = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 pec_vld", pec_vld, 0);
    check("R1 chk_vld", chk_vld, 0);
    check("R1 flags", {dev_err, crc_err}, 0);
  endtask

  task automatic t_ascii_vector;
    auto_en = 1; rd_dir = 0; sw_pec = 8'hAA;
    sop = 1; @(negedge clk); sop = 0;
    for (int i = 0; i < 9; i++) put(0, 8'h31 + i, i == 8);
    check("R2 R4 pec_vld", pec_vld, 1);
    check("R2 R4 vector 123456789", pec_byte, 8'hF4);
    check("R5 no sw_pec", pec_byte != 8'hAA, 1);
    idle(1);
    check("R4 single pulse", pec_vld, 0);
  endtask

  task automatic t_single_vector;
    put(1, 8'h01, 1);
    check("R2 R3 vector 01 with sop", pec_byte, 8'h07);
    sw_pec = 8'h07;
    put(1, 8'h31, 0); put(0, 8'h32, 1);
    check("R3 R5 two bytes", pec_byte, ref_crc(ref_crc(0, 8'h31), 8'h32));
    idle(1);
  endtask

  task automatic t_read(input logic corrupt);
    logic [7:0] c;
    logic [7:0] seq [5] = '{8'hA0, 8'h10, 8'hA1, 8'h5C, 8'hE3};
    auto_en = 1; c = 0;
    rd_dir = 1;
    for (int i = 0; i < 5; i++) begin
      put(i == 0, seq[i], 0);
      c = ref_crc(c, seq[i]);
    end
    put(0, corrupt ? (c ^ 8'h01) : c, 1);
    check("R8 chk_vld", chk_vld, 1);
    check("R8 chk_ok", chk_ok, !corrupt);
    check("R11 no pec on read", pec_vld, 0);
    if (corrupt) check("R9 both flags", {dev_err, crc_err}, 2'b11);
    idle(1);
    check("R8 chk pulse ends", chk_vld, 0);
  endtask

  task automatic t_clear;
    t_read(0);
    check("R12 R10 flags kept after good read", {dev_err, crc_err}, 2'b11);
    err_clr = 2'b10; @(negedge clk); err_clr = 0;
    check("R10 crc cleared only", {dev_err, crc_err}, 2'b10);
    err_clr = 2'b01; @(negedge clk); err_clr = 0;
    check("R10 dev cleared", {dev_err, crc_err}, 2'b00);
    t_read(0);
    check("R12 good read no flags", {dev_err, crc_err}, 2'b00);
  endtask

  task automatic t_modes;
    rd_dir = 0; auto_en = 0; man_pec_en = 1; sw_pec = 8'h5A;
    put(1, 8'h22, 0); put(0, 8'h33, 1);
    check("R6 manual pec_vld", pec_vld, 1);
    check("R6 manual byte", pec_byte, 8'h5A);
    idle(1);
    man_pec_en = 0;
    put(1, 8'h22, 0); put(0, 8'h33, 1);
    check("R7 disabled no pec", pec_vld, 0);
    idle(1);
    check("R7 still none", pec_vld, 0);
  endtask

  initial begin
    int cyc = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_ascii_vector();
        t_single_vector();
        t_read(0);
        check("R12 no flags after match", {dev_err, crc_err}, 0);
        t_read(1);
        t_clear();
        t_modes();
      end
      begin
        while (cyc < 20000) begin @(posedge clk); cyc++; end
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, 20000);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule